// File: doc/BRIEF.md
# Glitch-Free Clock Group Stop Controller

This block stops and restarts two gated clock groups, a processor group and a peripheral-bus group, in response to two active-low stop inputs. Each group has its own source clock. A free-running reference clock, which is never stopped, decides when a request becomes visible. An output being stopped always finishes its current high phase. While stopped it rests low. It restarts on a boundary that gives a whole high phase.

Each stop input is sampled into the reference domain through a chain of flops. The result is handed to a gate cell that loads its enable only on the falling edge of the clock it gates. The enable therefore changes only while that clock is low. A status flag for each group shows the real state of its gate, taken from the enable itself and not from the request. The two groups do not depend on each other.

Top module: `clock_stop_ctrl`

## Requirements
- R1: With `cpu_stop_n` held at 0 the output `cpu_clk_out` stays at 0. With it held at 1, `cpu_clk_out` follows `cpu_src_clk`.
- R2: With `pci_stop_n` held at 0 the output `pci_clk_out` stays at 0. With it held at 1, `pci_clk_out` follows `pci_src_clk`. Either stop input has no effect on the other group.
- R3: A stop request takes effect only after it has been seen on `SYNC_STAGES` (default 2) rising edges of `ref_clk`, and then only on the next falling edge of the gated source. Before the first of those reference edges, the gate is still open.
- R4: A restart follows the same rule as R3: first the reference rising edges, then a falling edge of the source, and only then are high phases passed again.
- R5: Every high pulse on a gated output lasts exactly one full high phase of its source. No pulse is shortened.
- R6: A stopped output rests at logic 0.
- R7: `cpu_halted` and `pci_halted` are 1 exactly while the gate of their group is closed. Each flag changes on a falling edge of its source.
- R8: A stop pulse that begins and ends between two rising edges of `ref_clk` is cancelled. It has no effect on the gated output or on the status flag.
- R9: While `rst_n` is 0, both gates are open and both status flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_clk | input | 1 | Free-running reference clock that times the requests |
| cpu_src_clk | input | 1 | Source clock of the processor group |
| pci_src_clk | input | 1 | Source clock of the peripheral-bus group |
| cpu_stop_n | input | 1 | Active-low stop request for the processor group |
| pci_stop_n | input | 1 | Active-low stop request for the peripheral-bus group |
| cpu_clk_out | output | 1 | Gated processor clock |
| pci_clk_out | output | 1 | Gated peripheral-bus clock |
| cpu_halted | output | 1 | Processor gate closed |
| pci_halted | output | 1 | Peripheral-bus gate closed |

## Verification
The gate state sets both the gated clock and the status flag, so an enable that is wrong shows on the next falling edge of the source. A flag disagrees with the output level within one source period: it reads running while the output stays low, or stopped while a pulse passes. An enable that is loaded on the wrong edge shows at once as a high pulse shorter than the source high phase. A synchronizer that is too short or bypassed shows within one reference period, as a stop that occurs too early or a narrow request that is not cancelled.

// File: rtl/clock_stop_pkg.sv
`timescale 1ns/1ps
package clock_stop_pkg;
  localparam int GRP_N   = 2;
  localparam int GRP_CPU = 0;
  localparam int GRP_PCI = 1;
  typedef logic [GRP_N-1:0] grp_vec_t;
endpackage

// File: rtl/clock_stop_sync.sv
`timescale 1ns/1ps
module clock_stop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  // reset value 1 means "run"
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/clock_stop_gate.sv
`timescale 1ns/1ps
module clock_stop_gate (
  input  logic src_clk,
  input  logic rst_n,
  input  logic run_req,
  output logic gclk,
  output logic halted
);
  logic en_q;
  logic en_d;
  logic en_ld;

  always_comb begin
    en_ld = (run_req != en_q);
    en_d  = en_ld ? run_req : en_q;
  end

  // loaded only on the falling edge: source is low whenever enable moves
  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= en_d;
  end

  assign gclk   = src_clk & en_q;
  assign halted = ~en_q;
endmodule

// File: rtl/clock_stop_ctrl.sv
`timescale 1ns/1ps
module clock_stop_ctrl
  import clock_stop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic rst_n,
  input  logic ref_clk,
  input  logic cpu_src_clk,
  input  logic pci_src_clk,
  input  logic cpu_stop_n,
  input  logic pci_stop_n,
  output logic cpu_clk_out,
  output logic pci_clk_out,
  output logic cpu_halted,
  output logic pci_halted
);
  grp_vec_t src_clk_v;
  grp_vec_t stop_n_v;
  grp_vec_t run_v;
  grp_vec_t gclk_v;
  grp_vec_t halt_v;

  assign src_clk_v[GRP_CPU] = cpu_src_clk;
  assign src_clk_v[GRP_PCI] = pci_src_clk;
  assign stop_n_v[GRP_CPU]  = cpu_stop_n;
  assign stop_n_v[GRP_PCI]  = pci_stop_n;

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    clock_stop_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .d     (stop_n_v[g]),
      .q     (run_v[g])
    );
    clock_stop_gate gate_i (
      .src_clk (src_clk_v[g]),
      .rst_n   (rst_n),
      .run_req (run_v[g]),
      .gclk    (gclk_v[g]),
      .halted  (halt_v[g])
    );
  end

  assign cpu_clk_out = gclk_v[GRP_CPU];
  assign pci_clk_out = gclk_v[GRP_PCI];
  assign cpu_halted  = halt_v[GRP_CPU];
  assign pci_halted  = halt_v[GRP_PCI];
endmodule

// File: rtl/clock_stop_ctrl_chk.sv
`timescale 1ns/1ps
module clock_stop_ctrl_chk (
  input logic rst_n,
  input logic ref_clk,
  input logic cpu_src_clk,
  input logic pci_src_clk,
  input logic cpu_stop_n,
  input logic pci_stop_n,
  input logic cpu_clk_out,
  input logic pci_clk_out,
  input logic cpu_halted,
  input logic pci_halted
);
  // R5
  cpu_run_full_high_chk: assert property (@(negedge cpu_src_clk) disable iff (!rst_n)
    !cpu_halted |-> cpu_clk_out);
  // R6
  cpu_stop_low_chk: assert property (@(negedge cpu_src_clk) disable iff (!rst_n)
    cpu_halted |-> !cpu_clk_out);
  // R3
  cpu_close_after_pulse_chk: assert property (@(negedge cpu_src_clk) disable iff (!rst_n)
    $rose(cpu_halted) |-> $past(cpu_clk_out));
  // R4
  cpu_open_from_low_chk: assert property (@(negedge cpu_src_clk) disable iff (!rst_n)
    $fell(cpu_halted) |-> !$past(cpu_clk_out));
  // R5
  pci_run_full_high_chk: assert property (@(negedge pci_src_clk) disable iff (!rst_n)
    !pci_halted |-> pci_clk_out);
  // R6
  pci_stop_low_chk: assert property (@(negedge pci_src_clk) disable iff (!rst_n)
    pci_halted |-> !pci_clk_out);
  // R3
  pci_close_after_pulse_chk: assert property (@(negedge pci_src_clk) disable iff (!rst_n)
    $rose(pci_halted) |-> $past(pci_clk_out));
  // R4
  pci_open_from_low_chk: assert property (@(negedge pci_src_clk) disable iff (!rst_n)
    $fell(pci_halted) |-> !$past(pci_clk_out));
endmodule

bind clock_stop_ctrl clock_stop_ctrl_chk chk_i (.*);

// File: tb/clock_stop_ctrl_tb.sv
`timescale 1ns/1ps
module clock_stop_ctrl_tb_top;
  logic rst_n, ref_clk, cpu_src_clk, pci_src_clk, cpu_stop_n, pci_stop_n;
  logic cpu_clk_out, pci_clk_out, cpu_halted, pci_halted;

  int checks = 0;
  int failures = 0;
  int cpu_edges = 0;
  int pci_edges = 0;
  int cpu_halt_rises = 0;
  realtime cpu_t, pci_t;
  bit cpu_seen = 0, pci_seen = 0;

  clock_stop_ctrl dut_i (.*);

  initial ref_clk = 1'b0;
  always #5 ref_clk = ~ref_clk;
  initial cpu_src_clk = 1'b0;
  always #3.5 cpu_src_clk = ~cpu_src_clk;
  initial pci_src_clk = 1'b0;
  always #6 pci_src_clk = ~pci_src_clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge cpu_clk_out) begin cpu_edges++; cpu_t = $realtime; cpu_seen = 1; end
  always @(posedge pci_clk_out) begin pci_edges++; pci_t = $realtime; pci_seen = 1; end
  always @(posedge cpu_halted) cpu_halt_rises++;

  // R5: every high pulse is a full source high phase
  always @(negedge cpu_clk_out) if (rst_n && cpu_seen) begin
    realtime w;
    w = $realtime - cpu_t;
    check(w > 3.49 && w < 3.51, "R5 cpu pulse width ps", int'(w*1000), 3500);
  end
  always @(negedge pci_clk_out) if (rst_n && pci_seen) begin
    realtime w;
    w = $realtime - pci_t;
    check(w > 5.99 && w < 6.01, "R5 pci pulse width ps", int'(w*1000), 6000);
  end

  // bits: cpu_stop_n, pci_stop_n, expected cpu_halted, expected pci_halted
  localparam logic [3:0] VEC [6] = '{4'b1100, 4'b0110, 4'b1001, 4'b0011, 4'b1100, 4'b0110};

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int c0, p0;
    rst_n = 1'b0; cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
    #23;
    // R9 reset state
    check(cpu_halted == 1'b0, "R9 cpu_halted in reset", cpu_halted, 0);
    check(pci_halted == 1'b0, "R9 pci_halted in reset", pci_halted, 0);
    @(posedge ref_clk); #1 rst_n = 1'b1;

    // R1 R2 R6 R7 table walk
    foreach (VEC[i]) begin
      cpu_stop_n = VEC[i][3];
      pci_stop_n = VEC[i][2];
      #80;
      check(cpu_halted == VEC[i][1], "R7 cpu_halted", cpu_halted, VEC[i][1]);
      check(pci_halted == VEC[i][0], "R7 pci_halted", pci_halted, VEC[i][0]);
      c0 = cpu_edges; p0 = pci_edges;
      #50;
      if (VEC[i][1]) begin
        check(cpu_edges == c0, "R1 cpu stopped edges", cpu_edges - c0, 0);
        check(cpu_clk_out == 1'b0, "R6 cpu rests low", cpu_clk_out, 0);
      end else
        check(cpu_edges - c0 >= 3, "R1 cpu running edges", cpu_edges - c0, 7);
      if (VEC[i][0]) begin
        check(pci_edges == p0, "R2 pci stopped edges", pci_edges - p0, 0);
        check(pci_clk_out == 1'b0, "R6 pci rests low", pci_clk_out, 0);
      end else
        check(pci_edges - p0 >= 3, "R2 pci running edges", pci_edges - p0, 4);
    end

    // R3: stop not applied before reference edges
    cpu_stop_n = 1'b1; pci_stop_n = 1'b1; #80;
    @(posedge ref_clk); #1 cpu_stop_n = 1'b0;
    #1 check(cpu_halted == 1'b0, "R3 cpu gate open right after pin", cpu_halted, 0);
    #13 check(cpu_halted == 1'b0, "R3 cpu gate open after one ref edge", cpu_halted, 0);
    #40 check(cpu_halted == 1'b1, "R3 cpu gate closed later", cpu_halted, 1);
    check(pci_halted == 1'b0, "R2 pci unaffected", pci_halted, 0);

    // R4: restart follows same rule
    @(posedge ref_clk); #1 cpu_stop_n = 1'b1;
    #1 check(cpu_halted == 1'b1, "R4 cpu still closed right after pin", cpu_halted, 1);
    #13 check(cpu_halted == 1'b1, "R4 cpu still closed after one ref edge", cpu_halted, 1);
    #40 check(cpu_halted == 1'b0, "R4 cpu reopened", cpu_halted, 0);

    // R8: narrow stop pulse between reference edges is cancelled
    #40;
    c0 = cpu_halt_rises;
    @(posedge ref_clk); #2 cpu_stop_n = 1'b0;
    #4 cpu_stop_n = 1'b1;
    p0 = cpu_edges;
    #60;
    check(cpu_halt_rises == c0, "R8 cpu_halted never rose", cpu_halt_rises - c0, 0);
    check(cpu_edges - p0 >= 6, "R8 cpu kept running", cpu_edges - p0, 8);

    // R9: reset reopens a closed gate
    pci_stop_n = 1'b0; #80;
    check(pci_halted == 1'b1, "R7 pci closed before reset", pci_halted, 1);
    rst_n = 1'b0; #3;
    check(pci_halted == 1'b0, "R9 pci reopened by reset", pci_halted, 0);
    pci_stop_n = 1'b1;
    @(posedge ref_clk); #1 rst_n = 1'b1;
    #40;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule